// File: doc/BRIEF.md
# I/O-Port-Driven Memory Bank Controller

This block holds the memory-map state of a CPU system with a 64 KB address space and changes it when the CPU touches one of seven bank ports at I/O addresses $E0 through $E6. Only the low byte of the I/O address is decoded. The data value of the access is never used, and the port number together with the access direction (write or read) picks the change. For every memory request the block drives a one-hot select toward one of five targets: DRAM, monitor ROM, character ROM, VRAM, or the key/timer window.

Two compatibility modes are chosen by the `mode_new` pin. Each mode has its own power-on map and its own extent for the switchable top region. The top region is $E000–$FFFF when `mode_new` is 1 and $D000–$FFFF when it is 0. The top region is a three-state machine with states TOP_DEV (devices mapped), TOP_DRAM and TOP_PROH (prohibited). Its transitions are:
- set-DRAM: moves from any state to TOP_DRAM.
- set-devices: moves from any state to TOP_DEV.
- power-on restore: moves from any state to TOP_DEV.
- prohibit: enters TOP_PROH and saves the state that was current.
- unprohibit: goes back to the saved state.

A separate overlay pair saves the character-ROM and VRAM-window bits on entry and brings them back on return. Each saved copy is a single register, so a repeated prohibit or overlay entry overwrites it.

Top module: `bank_map_ctrl`

## Requirements
- R1: After reset with `mode_new`=1, the map is as follows: $0000–$0FFF selects monitor ROM, $1000–$1FFF selects character ROM, $8000–$BFFF selects VRAM, $E000–$FFFF selects monitor ROM, and every other address selects DRAM.
- R2: After reset with `mode_new`=0, the map is as follows: $0000–$0FFF selects monitor ROM, $D000–$DFFF selects VRAM, $E000–$E007 selects key/timer, $E008–$FFFF selects monitor ROM, and every other address, including $1000–$1FFF and $C000–$CFFF, selects DRAM.
- R3: `sel` is zero whenever `mreq` is low. Otherwise it has at most one bit set, with bit 0 for DRAM, bit 1 for monitor ROM, bit 2 for character ROM, bit 3 for VRAM and bit 4 for key/timer. Exactly one bit is set outside a prohibited region.
- R4: An I/O write to $E0 maps $0000–$0FFF to DRAM, and with `mode_new`=1 it also maps $1000–$1FFF to DRAM. An I/O write to $E2 maps $0000–$0FFF back to monitor ROM.
- R5: An I/O write to $E1 maps the whole top region to DRAM. An I/O write to $E3 maps the top region back to its device layout: monitor ROM when `mode_new`=1, or VRAM, key/timer and monitor ROM when `mode_new`=0.
- R6: An I/O write to $E4 restores the complete power-on map of the current mode.
- R7: An I/O write to $E5 makes the top region prohibited, so a memory request there selects nothing. An I/O write to $E6 returns the top region to the state it had just before the prohibit.
- R8: A second write to $E5 before a write to $E6 overwrites the saved state with "prohibited", so the following $E6 leaves the region prohibited.
- R9: An I/O read of $E0 maps $1000–$1FFF to character ROM. It also maps $C000–$CFFF to VRAM when `mode_new`=0, or $8000–$BFFF to VRAM when `mode_new`=1. An I/O read of $E1 returns both ranges to their state before that read of $E0.
- R10: In `mode_new`=0 with the top region in its device layout, the key/timer select covers exactly the eight addresses $E000–$E007. $E008 is monitor ROM and $DFFF is VRAM.
- R11: Each I/O access acts once, on the cycle `iorq` first rises, however long `iorq` is held. The following have no effect on the map: the upper address byte, reads of ports $E2–$E6, and accesses to ports outside $E0–$E6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_new | input | 1 | Map mode select: 1 = newer map, 0 = older map |
| addr | input | 16 | CPU address; the low byte is the I/O port number during I/O cycles |
| mreq | input | 1 | Memory request, active high |
| iorq | input | 1 | I/O request, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| sel | output | 5 | One-hot target select: [0] DRAM, [1] monitor ROM, [2] character ROM, [3] VRAM, [4] key/timer |

## Verification
The assertions watch several properties on every cycle:
- the select is one-hot and is quiet without a memory request;
- a prohibited top region selects nothing;
- every decoded port command lasts exactly one cycle;
- each prohibit, unprohibit, overlay entry and power-on restore leaves the state it promises on the next cycle.

Only the bench scenarios can show which address ranges each command actually moves in each mode, and how the save slots behave. They cover the key/timer window edges at $E007 and $E008, the double-prohibit case, and how the saved state survives a long `iorq`. The same scenarios also show that reads of the wrong ports, accesses to out-of-range ports and a changed upper address byte leave every range unchanged.

// File: rtl/bank_pkg.sv
package bank_pkg;

    // Top region state machine
    typedef enum logic [1:0] {
        TOP_DEV  = 2'd0,
        TOP_DRAM = 2'd1,
        TOP_PROH = 2'd2
    } top_st_t;

    // Decoded bank port command
    typedef enum logic [3:0] {
        OP_NONE       = 4'd0,
        OP_LOW_DRAM   = 4'd1,
        OP_TOP_DRAM   = 4'd2,
        OP_LOW_ROM    = 4'd3,
        OP_TOP_DEV    = 4'd4,
        OP_POWERON    = 4'd5,
        OP_PROHIBIT   = 4'd6,
        OP_UNPROHIBIT = 4'd7,
        OP_OVL_ENTER  = 4'd8,
        OP_OVL_LEAVE  = 4'd9
    } bank_op_t;

    localparam int SEL_W      = 5;
    localparam int SEL_DRAM   = 0;
    localparam int SEL_MROM   = 1;
    localparam int SEL_CROM   = 2;
    localparam int SEL_VRAM   = 3;
    localparam int SEL_KEYTMR = 4;

endpackage

// File: rtl/bank_io_decode.sv
module bank_io_decode
    import bank_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          PORT_W    = 8,
    parameter logic [7:0]  PORT_BASE = 8'hE0,
    parameter int          NUM_PORTS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              iorq,
    input  logic              rd,
    input  logic              wr,
    output bank_op_t          op
);

    localparam int IDX_W = $clog2(NUM_PORTS);

    logic              iorq_q;
    logic              io_go;
    logic [PORT_W-1:0] port;
    logic [PORT_W-1:0] offset;
    logic              in_range;
    logic [IDX_W-1:0]  idx;

    always_ff @(posedge clk) begin
        if (!rst_n) iorq_q <= 1'b0;
        else        iorq_q <= iorq;
    end

    // Act only on the first cycle of an I/O access
    assign io_go    = iorq & ~iorq_q;
    assign port     = addr[PORT_W-1:0];
    assign offset   = port - PORT_W'(PORT_BASE);
    assign in_range = (port >= PORT_W'(PORT_BASE)) && (offset < PORT_W'(NUM_PORTS));
    assign idx      = offset[IDX_W-1:0];

    always_comb begin
        op = OP_NONE;
        if (io_go && in_range) begin
            if (wr) begin
                case (idx)
                    IDX_W'(0): op = OP_LOW_DRAM;
                    IDX_W'(1): op = OP_TOP_DRAM;
                    IDX_W'(2): op = OP_LOW_ROM;
                    IDX_W'(3): op = OP_TOP_DEV;
                    IDX_W'(4): op = OP_POWERON;
                    IDX_W'(5): op = OP_PROHIBIT;
                    IDX_W'(6): op = OP_UNPROHIBIT;
                    default:   op = OP_NONE;
                endcase
            end else if (rd) begin
                case (idx)
                    IDX_W'(0): op = OP_OVL_ENTER;
                    IDX_W'(1): op = OP_OVL_LEAVE;
                    default:   op = OP_NONE;
                endcase
            end
        end
    end

    AST_OP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_NONE) |=> (op == OP_NONE)); // R11

endmodule

// File: rtl/bank_state_fsm.sv
module bank_state_fsm
    import bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     mode_new,
    input  bank_op_t op,
    output logic     low_rom,
    output logic     cg_rom,
    output logic     win_vram,
    output top_st_t  top_st
);

    top_st_t top_q, top_d;
    top_st_t save_q, save_d;
    logic    low_q, low_d;
    logic    cg_q, cg_d;
    logic    win_q, win_d;
    logic    svcg_q, svcg_d;
    logic    svwin_q, svwin_d;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q   <= TOP_DEV;
            save_q  <= TOP_DEV;
            low_q   <= 1'b1;
            cg_q    <= mode_new;
            win_q   <= mode_new;
            svcg_q  <= mode_new;
            svwin_q <= mode_new;
        end else begin
            top_q   <= top_d;
            save_q  <= save_d;
            low_q   <= low_d;
            cg_q    <= cg_d;
            win_q   <= win_d;
            svcg_q  <= svcg_d;
            svwin_q <= svwin_d;
        end
    end

    // Next-state process
    always_comb begin
        top_d   = top_q;
        save_d  = save_q;
        low_d   = low_q;
        cg_d    = cg_q;
        win_d   = win_q;
        svcg_d  = svcg_q;
        svwin_d = svwin_q;
        unique case (op)
            OP_NONE:       ;
            OP_LOW_DRAM: begin
                low_d = 1'b0;
                if (mode_new) cg_d = 1'b0;
            end
            OP_LOW_ROM:    low_d = 1'b1;
            OP_TOP_DRAM:   top_d = TOP_DRAM;
            OP_TOP_DEV:    top_d = TOP_DEV;
            OP_POWERON: begin
                top_d = TOP_DEV;
                low_d = 1'b1;
                cg_d  = mode_new;
                win_d = mode_new;
            end
            OP_PROHIBIT: begin
                save_d = top_q;
                top_d  = TOP_PROH;
            end
            OP_UNPROHIBIT: top_d = save_q;
            OP_OVL_ENTER: begin
                svcg_d  = cg_q;
                svwin_d = win_q;
                cg_d    = 1'b1;
                win_d   = 1'b1;
            end
            OP_OVL_LEAVE: begin
                cg_d  = svcg_q;
                win_d = svwin_q;
            end
            default:       ;
        endcase
    end

    assign low_rom  = low_q;
    assign cg_rom   = cg_q;
    assign win_vram = win_q;
    assign top_st   = top_q;

    AST_PROH_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PROHIBIT) |=> (top_q == TOP_PROH && save_q == $past(top_q))); // R7
    AST_UNPROH_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_UNPROHIBIT) |=> (top_q == $past(save_q))); // R7
    AST_OVL_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_OVL_ENTER) |=> (cg_q && win_q)); // R9
    AST_POWERON_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POWERON) |=> (low_q && top_q == TOP_DEV)); // R6

endmodule

// File: rtl/bank_region_decode.sv
module bank_region_decode
    import bank_pkg::*;
#(
    parameter int              ADDR_W      = 16,
    parameter logic [15:0]     KEY_BASE    = 16'hE000,
    parameter int              KEY_SPAN_LG = 3
) (
    input  logic              mode_new,
    input  logic              mreq,
    input  logic [ADDR_W-1:0] addr,
    input  logic              low_rom,
    input  logic              cg_rom,
    input  logic              win_vram,
    input  top_st_t           top_st,
    output logic [SEL_W-1:0]  sel
);

    localparam int PG_W = 4;
    localparam logic [PG_W-1:0] PG_LOW   = 4'h0;
    localparam logic [PG_W-1:0] PG_CG    = 4'h1;
    localparam logic [PG_W-1:0] PG_WIN_O = 4'hC;
    localparam logic [PG_W-1:0] PG_VR_O  = 4'hD;
    localparam logic [PG_W-1:0] PG_TOP_N = 4'hE;
    localparam logic [PG_W-1:0] PG_WIN_N_LO = 4'h8;
    localparam logic [PG_W-1:0] PG_WIN_N_HI = 4'hB;

    logic [PG_W-1:0] page;
    logic            in_top;
    logic            in_win;
    logic            key_hit;

    assign page    = addr[ADDR_W-1 -: PG_W];
    assign in_top  = mode_new ? (page >= PG_TOP_N) : (page >= PG_VR_O);
    assign in_win  = mode_new ? (page >= PG_WIN_N_LO && page <= PG_WIN_N_HI)
                              : (page == PG_WIN_O);
    assign key_hit = (addr[ADDR_W-1:KEY_SPAN_LG] ==
                      KEY_BASE[ADDR_W-1:KEY_SPAN_LG]);

    always_comb begin
        sel = '0;
        if (mreq) begin
            if (page == PG_LOW) begin
                sel[low_rom ? SEL_MROM : SEL_DRAM] = 1'b1;
            end else if (page == PG_CG) begin
                sel[cg_rom ? SEL_CROM : SEL_DRAM] = 1'b1;
            end else if (in_top) begin
                unique case (top_st)
                    TOP_DEV: begin
                        if (mode_new)             sel[SEL_MROM]   = 1'b1;
                        else if (page == PG_VR_O) sel[SEL_VRAM]   = 1'b1;
                        else if (key_hit)         sel[SEL_KEYTMR] = 1'b1;
                        else                      sel[SEL_MROM]   = 1'b1;
                    end
                    TOP_DRAM: sel[SEL_DRAM] = 1'b1;
                    TOP_PROH: sel = '0;
                    default:  sel = '0;
                endcase
            end else if (in_win) begin
                sel[win_vram ? SEL_VRAM : SEL_DRAM] = 1'b1;
            end else begin
                sel[SEL_DRAM] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
    import bank_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_new,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mreq,
    input  logic              iorq,
    input  logic              rd,
    input  logic              wr,
    output logic [SEL_W-1:0]  sel
);

    bank_op_t op;
    logic     low_rom;
    logic     cg_rom;
    logic     win_vram;
    top_st_t  top_st;

    bank_io_decode #(
        .ADDR_W (ADDR_W)
    ) io_dec_i (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .iorq  (iorq),
        .rd    (rd),
        .wr    (wr),
        .op    (op)
    );

    bank_state_fsm state_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_new (mode_new),
        .op       (op),
        .low_rom  (low_rom),
        .cg_rom   (cg_rom),
        .win_vram (win_vram),
        .top_st   (top_st)
    );

    bank_region_decode #(
        .ADDR_W (ADDR_W)
    ) region_i (
        .mode_new (mode_new),
        .mreq     (mreq),
        .addr     (addr),
        .low_rom  (low_rom),
        .cg_rom   (cg_rom),
        .win_vram (win_vram),
        .top_st   (top_st),
        .sel      (sel)
    );

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R3
    AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mreq |-> (sel == '0)); // R3
    AST_SEL_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq && top_st != TOP_PROH) |-> ($countones(sel) == 1)); // R3
    AST_PROH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq && top_st == TOP_PROH && addr[ADDR_W-1 -: 3] == 3'b111) |-> (sel == '0)); // R7

endmodule

// File: tb/bank_map_ctrl_tb_top.sv
`timescale 1ns/1ps
module bank_map_ctrl_tb_top;

    localparam logic [4:0] E_NONE = 5'b00000;
    localparam logic [4:0] E_DRAM = 5'b00001;
    localparam logic [4:0] E_MROM = 5'b00010;
    localparam logic [4:0] E_CROM = 5'b00100;
    localparam logic [4:0] E_VRAM = 5'b01000;
    localparam logic [4:0] E_KT   = 5'b10000;

    typedef struct {
        logic [4:0]  exp;
        logic [15:0] a;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_new = 1'b1;
    logic [15:0] addr = '0;
    logic        mreq = 1'b0;
    logic        iorq = 1'b0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  sel;

    item_t q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    bank_map_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_new (mode_new),
        .addr     (addr),
        .mreq     (mreq),
        .iorq     (iorq),
        .rd       (rd),
        .wr       (wr),
        .sel      (sel)
    );

    // Monitor: pops one expected item per cycle, away from the edge
    always begin
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_vec++;
            if (sel !== it.exp) begin
                n_bad++;
                $display("FAIL %s addr=%h sel=%b expected=%b", it.tag, it.a, sel, it.exp);
            end
        end
    end

    task automatic probe(input logic [15:0] a, input logic m, input logic [4:0] e, input string tag);
        item_t it;
        @(negedge clk);
        addr = a;
        mreq = m;
        it.exp = e; it.a = a; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        mreq = 1'b0;
    endtask

    task automatic io(input logic [7:0] port, input logic is_rd, input logic [7:0] hi);
        @(negedge clk);
        addr = {hi, port};
        iorq = 1'b1;
        rd   = is_rd;
        wr   = ~is_rd;
        repeat (2) @(negedge clk);
        iorq = 1'b0;
        rd   = 1'b0;
        wr   = 1'b0;
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst_n    = 1'b0;
        mode_new = m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        // ---------- newer mode ----------
        do_reset(1'b1);
        probe(16'h0000, 1'b1, E_MROM, "R1 low rom");
        probe(16'h1000, 1'b1, E_CROM, "R1 char rom");
        probe(16'h2000, 1'b1, E_DRAM, "R1 dram mid");
        probe(16'h8000, 1'b1, E_VRAM, "R1 vram");
        probe(16'hC000, 1'b1, E_DRAM, "R1 dram C000");
        probe(16'hE000, 1'b1, E_MROM, "R1 top rom");
        probe(16'hFFFF, 1'b1, E_MROM, "R1 top rom end");
        probe(16'hE000, 1'b0, E_NONE, "R3 no mreq");

        io(8'hE0, 1'b0, 8'h12);
        probe(16'h0000, 1'b1, E_DRAM, "R4 E0 low");
        probe(16'h1FFF, 1'b1, E_DRAM, "R4 E0 cg");
        probe(16'h8000, 1'b1, E_VRAM, "R4 E0 vram kept");
        io(8'hE2, 1'b0, 8'h00);
        probe(16'h0FFF, 1'b1, E_MROM, "R4 E2 low");
        probe(16'h1000, 1'b1, E_DRAM, "R4 E2 cg stays");

        io(8'hE1, 1'b0, 8'h00);
        probe(16'hE000, 1'b1, E_DRAM, "R5 E1 top");
        probe(16'hD000, 1'b1, E_DRAM, "R5 D000 not top");
        io(8'hE3, 1'b0, 8'h00);
        probe(16'hF000, 1'b1, E_MROM, "R5 E3 top");

        io(8'hE5, 1'b0, 8'h00);
        probe(16'hE000, 1'b1, E_NONE, "R7 prohibited");
        probe(16'hD000, 1'b1, E_DRAM, "R7 below top");
        io(8'hE6, 1'b0, 8'h00);
        probe(16'hE000, 1'b1, E_MROM, "R7 restore dev");
        io(8'hE1, 1'b0, 8'h00);
        io(8'hE5, 1'b0, 8'h00);
        probe(16'hFFFF, 1'b1, E_NONE, "R7 prohibited from dram");
        io(8'hE6, 1'b0, 8'h00);
        probe(16'hE000, 1'b1, E_DRAM, "R7 R11 restore dram");

        io(8'hE5, 1'b0, 8'h00);
        io(8'hE5, 1'b0, 8'h00);
        io(8'hE6, 1'b0, 8'h00);
        probe(16'hE000, 1'b1, E_NONE, "R8 double prohibit");

        io(8'hE4, 1'b0, 8'h77);
        probe(16'hE000, 1'b1, E_MROM, "R6 top");
        probe(16'h0000, 1'b1, E_MROM, "R6 low");
        probe(16'h1000, 1'b1, E_CROM, "R6 cg");
        probe(16'h8000, 1'b1, E_VRAM, "R6 vram");

        io(8'hE0, 1'b0, 8'h00);
        io(8'hE0, 1'b1, 8'h00);
        probe(16'h1000, 1'b1, E_CROM, "R9 overlay cg");
        probe(16'hB000, 1'b1, E_VRAM, "R9 overlay vram");
        io(8'hE1, 1'b1, 8'h00);
        probe(16'h1000, 1'b1, E_DRAM, "R9 overlay return");

        io(8'hE2, 1'b1, 8'h00);
        probe(16'h0000, 1'b1, E_DRAM, "R11 read E2 ignored");
        io(8'hE5, 1'b1, 8'h00);
        probe(16'hE000, 1'b1, E_MROM, "R11 read E5 ignored");
        io(8'hE7, 1'b0, 8'h00);
        io(8'hDF, 1'b0, 8'h00);
        probe(16'h0000, 1'b1, E_DRAM, "R11 E7 DF ignored");
        probe(16'hE000, 1'b1, E_MROM, "R11 E7 DF top");

        // ---------- older mode ----------
        do_reset(1'b0);
        probe(16'h0000, 1'b1, E_MROM, "R2 low rom");
        probe(16'h1000, 1'b1, E_DRAM, "R2 cg dram");
        probe(16'h8000, 1'b1, E_DRAM, "R2 8000 dram");
        probe(16'hC000, 1'b1, E_DRAM, "R2 C000 dram");
        probe(16'hD000, 1'b1, E_VRAM, "R2 vram");
        probe(16'hDFFF, 1'b1, E_VRAM, "R10 DFFF vram");
        probe(16'hE000, 1'b1, E_KT,   "R10 key first");
        probe(16'hE007, 1'b1, E_KT,   "R10 timer last");
        probe(16'hE008, 1'b1, E_MROM, "R10 E008 rom");
        probe(16'hFFFF, 1'b1, E_MROM, "R2 top rom");

        io(8'hE0, 1'b0, 8'h00);
        probe(16'h0000, 1'b1, E_DRAM, "R4 older E0");
        io(8'hE1, 1'b0, 8'h00);
        probe(16'hD000, 1'b1, E_DRAM, "R5 older E1 D000");
        probe(16'hE003, 1'b1, E_DRAM, "R5 older E1 key");
        io(8'hE3, 1'b0, 8'h00);
        probe(16'hE004, 1'b1, E_KT,   "R5 older E3 timer");
        io(8'hE5, 1'b0, 8'h00);
        probe(16'hD800, 1'b1, E_NONE, "R7 older prohibited");
        io(8'hE6, 1'b0, 8'h00);
        probe(16'hD800, 1'b1, E_VRAM, "R7 older restore");

        io(8'hE0, 1'b1, 8'h00);
        probe(16'hC000, 1'b1, E_VRAM, "R9 older overlay vram");
        probe(16'h1000, 1'b1, E_CROM, "R9 older overlay cg");
        io(8'hE1, 1'b1, 8'h00);
        probe(16'hC000, 1'b1, E_DRAM, "R9 older return vram");
        probe(16'h1000, 1'b1, E_DRAM, "R9 older return cg");

        io(8'hE4, 1'b0, 8'h00);
        probe(16'h0000, 1'b1, E_MROM, "R6 older low");
        probe(16'hE000, 1'b1, E_KT,   "R6 older key");

        wait (q.size() == 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule